// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is the target side of a two-wire bus that looks like a byte-wide serial EEPROM to a controller. It watches the clock and data lines, answers only to device address 0x57, takes a two-byte word address and then either receives data to store or returns stored bytes. It never drives a line high. It only pulls data low, through an open-drain enable.

An address counter is held between transfers. A controller can therefore do a random read in three steps: it points the counter with a write-type header, sends a repeated START, and then reads. It can also keep reading from wherever the last access ended. Written bytes first collect in a 32-byte page buffer. They reach the storage array only after STOP. A fixed-length busy window then follows, and during it the target refuses its own address, so a controller can poll until it gets an acknowledge.

The word counter is 15 bits wide. The storage array is sized by a parameter, and any upper counter bits that the array does not hold fold onto the lower locations.

Top module: `eep_i2c_target`

## Requirements
- R1: The target acknowledges a header whose upper seven bits are 0x57. Any other header is not acknowledged, and every byte after it is ignored until the next START. Header bit 0 selects write (0) or read (1).
- R2: In a write transfer the target acknowledges, by holding data low in the ninth clock, the header, the high address byte, the low address byte and every data byte.
- R3: The high address byte supplies counter bits 14..8. Its bit 7 is ignored, so addresses 0x9234 and 0x1234 name the same location.
- R4: After a write header and two address bytes, a repeated START followed by a read header returns the byte stored at that address, most significant bit first.
- R5: Written data reaches the storage array only after STOP. A read made before that STOP, through a repeated START, still returns the old contents.
- R6: The counter advances by one after each byte read. Sequential reads continue from it, and the counter wraps from 0x7FFF to 0x0000.
- R7: A page write keeps counter bits 14..5 fixed and advances only the low five bits, modulo 32. Bytes beyond the page end overwrite the start of the same page, and locations not written keep their contents.
- R8: For WR_CYCLES clock cycles after a STOP that ends a transfer holding write data, the target does not acknowledge its own header. After that window it acknowledges again.
- R9: The data line is released after reset, and also after the controller answers a read byte with a not-acknowledge. The target changes its drive on the data line only while the clock line is low.
- R10: The counter survives a STOP. A read header sent without address bytes starts at the location that follows the last byte accessed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge or a 0 data bit) |

## Verification
The main function is tried with several transfer shapes:
- A single-byte write followed by a random read shows that storing and addressing work.
- A four-byte page write starting two bytes before a page end separates a page-local wrap from a plain increment, because it must land back on the first bytes of the same page and leave their neighbours untouched.
- A read issued by repeated START while write data is still pending separates commit-at-STOP from immediate writing.
- A read sent without address bytes after an earlier transfer checks that the counter is kept between transfers.
- Two reads checked for the address folding: one where the top address bit is set, and one where the counter runs across 0x7FFF.
- A wrong device address, and polling straight after a commit, check the refusal paths.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam logic [6:0] DEV_ID = 7'h57;
    localparam int CNT_W  = 15;
    localparam int PAGE_W = 5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CTRL,
        PH_AH,
        PH_AL,
        PH_WR,
        PH_RD
    } phase_t;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic ctrl_match(logic [7:0] hdr, logic busy);
        return (hdr[7:1] == DEV_ID) && !busy;
    endfunction

    function automatic logic [CNT_W-1:0] page_next(logic [CNT_W-1:0] a);
        return {a[CNT_W-1:PAGE_W], a[PAGE_W-1:0] + 1'b1};
    endfunction

endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync
    import eep_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [2:0] scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[1:0], scl_i};
            sda_q <= {sda_q[1:0], sda_i};
        end
    end

    always_comb begin
        ev.sda      = sda_q[1];
        ev.scl_rise = scl_q[1] & ~scl_q[2];
        ev.scl_fall = ~scl_q[1] & scl_q[2];
        ev.start    = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
        ev.stop     = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
    end
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf
    import eep_pkg::*;
#(
    parameter int AW        = 10,
    parameter int WR_CYCLES = 1250000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic [AW-PAGE_W-1:0] base_i,
    input  logic                 wr_en,
    input  logic [PAGE_W-1:0]    wr_idx,
    input  logic [7:0]           wr_data,
    input  logic                 commit_req,
    output logic                 busy_o,
    output logic                 mem_we_o,
    output logic [AW-1:0]        mem_addr_o,
    output logic [7:0]           mem_data_o
);
    localparam int DEPTH = 1 << PAGE_W;
    localparam int TW    = $clog2(WR_CYCLES + 1);

    logic [7:0]           data_q [DEPTH];
    logic [DEPTH-1:0]     vld_q;
    logic                 scan_q;
    logic [PAGE_W-1:0]    idx_q;
    logic [TW-1:0]        tmr_q;
    logic [AW-PAGE_W-1:0] base_q;

    assign busy_o     = scan_q || (tmr_q != '0);
    assign mem_we_o   = scan_q && vld_q[idx_q];
    assign mem_addr_o = {base_q, idx_q};
    assign mem_data_o = data_q[idx_q];

    always_ff @(posedge clk) begin
        if (wr_en) data_q[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= '0;
            scan_q <= 1'b0;
            idx_q  <= '0;
            tmr_q  <= '0;
            base_q <= '0;
        end else begin
            if (tmr_q != '0) tmr_q <= tmr_q - TW'(1);
            if (commit_req && !busy_o && (|vld_q)) begin
                scan_q <= 1'b1;
                idx_q  <= '0;
                tmr_q  <= TW'(WR_CYCLES);
            end
            if (scan_q) begin
                idx_q <= idx_q + 1'b1;
                if (&idx_q) begin
                    scan_q <= 1'b0;
                    vld_q  <= '0;
                end
            end
            if (clear) begin
                vld_q  <= '0;
                base_q <= base_i;
            end
            if (wr_en) vld_q[wr_idx] <= 1'b1;
        end
    end
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] arr_q [1 << AW];

    always_ff @(posedge clk) begin
        if (we) arr_q[waddr] <= wdata;
        rdata <= arr_q[raddr];
    end
endmodule

// File: rtl/eep_i2c_target.sv
module eep_i2c_target
    import eep_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int WR_CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o
);
    localparam int BASE_W = ADDR_W - PAGE_W;

    bus_ev_t          ev;
    phase_t           phase_q, nxt_q;
    logic [CNT_W-1:0] cnt_q;
    logic [3:0]       bit_q;
    logic [7:0]       sh_q;
    logic             ack_slot_q, drv_q, more_q;
    logic             busy, mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]       mem_wdata, mem_rdata;
    logic             byte_done, pb_wr, pb_clear;

    assign sda_oe_o  = drv_q;
    assign byte_done = ev.scl_fall && !ack_slot_q && (bit_q == 4'd8) && !ev.start && !ev.stop;
    assign pb_wr     = byte_done && (phase_q == PH_WR);
    assign pb_clear  = byte_done && (phase_q == PH_AL);

    eep_bus_sync u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    eep_page_buf #(.AW(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_pbuf (
        .clk(clk), .rst(rst),
        .clear(pb_clear),
        .base_i(BASE_W'({cnt_q[CNT_W-1:8], sh_q[7:PAGE_W]})),
        .wr_en(pb_wr), .wr_idx(cnt_q[PAGE_W-1:0]), .wr_data(sh_q),
        .commit_req(ev.stop),
        .busy_o(busy), .mem_we_o(mem_we), .mem_addr_o(mem_waddr), .mem_data_o(mem_wdata)
    );

    eep_mem #(.AW(ADDR_W)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(cnt_q[ADDR_W-1:0]), .rdata(mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            nxt_q      <= PH_IDLE;
            cnt_q      <= '0;
            bit_q      <= '0;
            sh_q       <= '0;
            ack_slot_q <= 1'b0;
            drv_q      <= 1'b0;
            more_q     <= 1'b0;
        end else if (ev.start) begin
            phase_q    <= PH_CTRL;
            bit_q      <= '0;
            ack_slot_q <= 1'b0;
            drv_q      <= 1'b0;
        end else if (ev.stop) begin
            phase_q    <= PH_IDLE;
            ack_slot_q <= 1'b0;
            drv_q      <= 1'b0;
        end else if (phase_q == PH_RD) begin
            if (ev.scl_rise && !ack_slot_q) begin
                sh_q  <= {sh_q[6:0], 1'b0};
                bit_q <= bit_q + 1'b1;
            end else if (ev.scl_fall && !ack_slot_q) begin
                if (bit_q == 4'd8) begin
                    drv_q      <= 1'b0;
                    ack_slot_q <= 1'b1;
                end else begin
                    drv_q <= ~sh_q[7];
                end
            end else if (ev.scl_rise && ack_slot_q) begin
                more_q <= ~ev.sda;
                cnt_q  <= cnt_q + 1'b1;
            end else if (ev.scl_fall && ack_slot_q) begin
                ack_slot_q <= 1'b0;
                bit_q      <= '0;
                if (more_q) begin
                    sh_q  <= mem_rdata;
                    drv_q <= ~mem_rdata[7];
                end else begin
                    phase_q <= PH_IDLE;
                    drv_q   <= 1'b0;
                end
            end
        end else if (phase_q != PH_IDLE) begin
            if (ev.scl_rise && !ack_slot_q && (bit_q != 4'd8)) begin
                sh_q  <= {sh_q[6:0], ev.sda};
                bit_q <= bit_q + 1'b1;
            end else if (byte_done) begin
                ack_slot_q <= 1'b1;
                drv_q      <= 1'b1;
                case (phase_q)
                    PH_CTRL: begin
                        if (ctrl_match(sh_q, busy)) begin
                            nxt_q <= sh_q[0] ? PH_RD : PH_AH;
                        end else begin
                            phase_q    <= PH_IDLE;
                            ack_slot_q <= 1'b0;
                            drv_q      <= 1'b0;
                        end
                    end
                    PH_AH: begin
                        cnt_q[CNT_W-1:8] <= sh_q[6:0];
                        nxt_q            <= PH_AL;
                    end
                    PH_AL: begin
                        cnt_q[7:0] <= sh_q;
                        nxt_q      <= PH_WR;
                    end
                    default: begin
                        cnt_q <= page_next(cnt_q);
                        nxt_q <= PH_WR;
                    end
                endcase
            end else if (ev.scl_fall && ack_slot_q) begin
                ack_slot_q <= 1'b0;
                bit_q      <= '0;
                phase_q    <= nxt_q;
                if (nxt_q == PH_RD) begin
                    sh_q  <= mem_rdata;
                    drv_q <= ~mem_rdata[7];
                end else begin
                    drv_q <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/eep_i2c_target_chk.sv
module eep_i2c_target_chk
    import eep_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input phase_t           phase,
    input logic             ack_slot,
    input logic             busy,
    input logic             sda_oe,
    input logic             scl,
    input logic             stop_det,
    input logic             mem_we,
    input logic [CNT_W-1:0] cnt
);
    a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl);

    a_r5_commit_after_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_det));

    a_r5_no_array_write_while_receiving: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (phase != PH_WR));

    a_r8_busy_no_ctrl_ack: assert property (@(posedge clk) disable iff (rst)
        busy |-> !(ack_slot && phase == PH_CTRL));

    a_r7_page_fixed_in_write: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WR && $past(phase) == PH_WR) |-> $stable(cnt[CNT_W-1:PAGE_W]));
endmodule

bind eep_i2c_target eep_i2c_target_chk u_chk (
    .clk(clk), .rst(rst), .phase(phase_q), .ack_slot(ack_slot_q), .busy(busy),
    .sda_oe(sda_oe_o), .scl(scl_i), .stop_det(ev.stop), .mem_we(mem_we), .cnt(cnt_q)
);

// File: tb/eep_i2c_target_bench.sv
module eep_i2c_target_bench;
    localparam int Q   = 10;
    localparam int WRC = 1500;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic ctl_low = 1'b0;
    logic sda_oe;
    logic sda_bus;

    assign sda_bus = ~(ctl_low | sda_oe);

    always #2 clk = ~clk;

    eep_i2c_target #(.ADDR_W(10), .WR_CYCLES(WRC)) u_eep_i2c_target (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] obs_v;
    event       obs_ev;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(obs_ev);
            if (exp_q.size() == 0) chk("scoreboard_empty", obs_v, 8'hxx);
            else chk(tag_q.pop_front(), obs_v, exp_q.pop_front());
        end
    end

    task automatic observe(input logic [7:0] v);
        obs_v = v;
        -> obs_ev;
        @(posedge clk); #1;
    endtask

    task automatic wq();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b);
        ctl_low = ~b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        ctl_low = 1'b0; wq(); scl = 1'b1; wq(); b = sda_bus; wq(); scl = 1'b0; wq();
    endtask

    task automatic i2c_start();
        ctl_low = 1'b0; wq(); scl = 1'b1; wq(); ctl_low = 1'b1; wq(); scl = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        ctl_low = 1'b1; wq(); scl = 1'b1; wq(); ctl_low = 1'b0; wq();
    endtask

    // exp_ack: 0 = acknowledge (data held low), 1 = not acknowledged
    task automatic tx_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        logic a;
        exp_q.push_back({7'd0, exp_ack});
        tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(a);
        observe({7'd0, a});
    endtask

    task automatic rx_byte(input logic [7:0] exp, input logic more, input string tag);
        logic [7:0] v;
        logic b;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        observe(v);
        send_bit(~more);
        if (!more) chk("R9 released after nack", {7'd0, sda_oe}, 8'h00);
    endtask

    task automatic set_addr(input logic [15:0] a, input string tag);
        tx_byte(8'hAE, 1'b0, tag);
        tx_byte(a[15:8], 1'b0, tag);
        tx_byte(a[7:0], 1'b0, tag);
    endtask

    task automatic write_bytes(input logic [15:0] a, input logic [7:0] d [4], input int n, input string tag);
        i2c_start();
        set_addr(a, tag);
        for (int i = 0; i < n; i++) tx_byte(d[i], 1'b0, tag);
        i2c_stop();
        repeat (WRC + 100) @(posedge clk);
        #1;
    endtask

    task automatic read_bytes(input logic [15:0] a, input logic [7:0] e [4], input int n, input string tag);
        i2c_start();
        set_addr(a, tag);
        i2c_start();
        tx_byte(8'hAF, 1'b0, tag);
        for (int i = 0; i < n; i++) rx_byte(e[i], (i != n - 1), tag);
        i2c_stop();
        wq();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        rst = 1'b0;
        repeat (5) @(posedge clk);
        #1;
        chk("R9 reset released", {7'd0, sda_oe}, 8'h00);

        // R1: foreign address refused, later bytes ignored until START
        i2c_start();
        tx_byte(8'hA0, 1'b1, "R1 foreign header nack");
        tx_byte(8'hAE, 1'b1, "R1 ignored until start");
        i2c_stop();
        wq();

        // R2 / R4: single byte write and random read
        write_bytes(16'h0123, '{8'h3C, 8'h00, 8'h00, 8'h00}, 1, "R2 byte write ack");
        read_bytes(16'h0123, '{8'h3C, 8'h00, 8'h00, 8'h00}, 1, "R4 random read");

        // R10 / R6: counter kept over STOP, sequential continuation
        write_bytes(16'h0040, '{8'hA0, 8'hA1, 8'hA2, 8'hA3}, 4, "R2 page write ack");
        read_bytes(16'h0040, '{8'hA0, 8'h00, 8'h00, 8'h00}, 1, "R4 read page start");
        i2c_start();
        tx_byte(8'hAF, 1'b0, "R10 read header ack");
        rx_byte(8'hA1, 1'b1, "R10 counter kept after stop");
        rx_byte(8'hA2, 1'b0, "R6 sequential increment");
        i2c_stop();
        wq();

        // R7: page-local wrap
        write_bytes(16'h005E, '{8'h51, 8'h52, 8'h53, 8'h54}, 4, "R7 wrap write ack");
        read_bytes(16'h0040, '{8'h53, 8'h54, 8'hA2, 8'hA3}, 4, "R7 wrapped to page start");
        read_bytes(16'h005E, '{8'h51, 8'h52, 8'h00, 8'h00}, 2, "R7 page end bytes");

        // R5: pending data invisible before STOP
        i2c_start();
        set_addr(16'h0040, "R5 setup");
        tx_byte(8'h77, 1'b0, "R5 data ack");
        i2c_start();
        tx_byte(8'hAF, 1'b0, "R5 read header");
        rx_byte(8'h54, 1'b0, "R5 old contents before stop");
        i2c_stop();

        // R8: busy polling
        i2c_start();
        tx_byte(8'hAE, 1'b1, "R8 nack while busy");
        i2c_stop();
        repeat (WRC + 100) @(posedge clk);
        #1;
        i2c_start();
        tx_byte(8'hAE, 1'b0, "R8 ack after busy window");
        i2c_stop();
        wq();
        read_bytes(16'h0040, '{8'h77, 8'h00, 8'h00, 8'h00}, 1, "R5 committed at stop");

        // R3: top address bit ignored
        write_bytes(16'h9234, '{8'h6D, 8'h00, 8'h00, 8'h00}, 1, "R3 write high alias");
        read_bytes(16'h1234, '{8'h6D, 8'h00, 8'h00, 8'h00}, 1, "R3 bit15 ignored");

        // R6: wrap from 0x7FFF to 0x0000
        write_bytes(16'h7FFF, '{8'hE1, 8'h00, 8'h00, 8'h00}, 1, "R6 write top");
        write_bytes(16'h0000, '{8'hE2, 8'h00, 8'h00, 8'h00}, 1, "R6 write bottom");
        read_bytes(16'h7FFF, '{8'hE1, 8'hE2, 8'h00, 8'h00}, 2, "R6 counter wrap");

        repeat (20) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule